// File: doc/BRIEF.md
# USB Periodic Transaction Cost Calculator

This block turns the description of one periodic USB transaction into the number of bytes of bus time that the transaction uses. A scheduler gives it the bus speed, whether the endpoint is isochronous, the data direction, the split phase, the maximum packet size and, for high speed, how many transactions run in each microframe. The block returns a byte cost. The cost includes a worst-case bit-stuffing allowance on the payload, a per-speed protocol overhead, a fixed host delay and, where a split applies, the split overhead.

A request is a single-cycle strobe. One clock later the block raises a one-cycle valid strobe together with the registered cost and an error flag. An unsupported request still produces a valid strobe. Its error flag is set and its cost is zero.

Top module: `usb_xact_cost`

## Requirements
- R1: The stuffed payload term P equals floor(mps_i * 7 / 6), truncated toward zero.
- R2: At full speed (speed_i = 0) the cost is O + P + 18, where O is 14 when iso_i = 0, 10 for isochronous host-to-device (iso_i = 1, dir_in_i = 0) and 11 for isochronous device-to-host (iso_i = 1, dir_in_i = 1).
- R3: At low speed (speed_i = 1) the cost is 97 + 1 + 8*P + 18, whatever the values of iso_i and dir_in_i.
- R4: At high speed (speed_i = 2) with split_i = 0, the cost is (H + P + 18) * mult_i. H is 55 when iso_i = 0 and 38 when iso_i = 1.
- R5: At high speed with split_i = 1 (start phase), the cost is H + 18 + 4, plus P only when dir_in_i = 0 (host-to-device). mult_i has no effect.
- R6: At high speed with split_i = 2 (complete phase), the cost is H + 18 + 4, plus P only when dir_in_i = 1 (device-to-host). mult_i has no effect.
- R7: valid_o is high for exactly one cycle, in the cycle after each cycle in which req_i is high. It is low in every other cycle.
- R8: The block sets err_o and drives cost_o to 0 in any of these cases: mps_i above 1024, speed_i = 3, or high speed with split_i = 3. It does the same at high speed with split_i = 0 and a mult_i outside the range 1 to 3.
- R9: While rst_ni is low, valid_o, err_o and cost_o are all 0.
- R10: At full and low speed, split_i and mult_i have no effect on the cost or on err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe; the other inputs are sampled with it |
| speed_i | input | 2 | 0 full, 1 low, 2 high, 3 reserved |
| iso_i | input | 1 | 1 for an isochronous endpoint |
| dir_in_i | input | 1 | 1 for device-to-host |
| split_i | input | 2 | 0 no split, 1 start, 2 complete, 3 reserved |
| mult_i | input | 2 | Transactions per microframe (high speed, no split) |
| mps_i | input | 11 | Maximum packet size in bytes |
| valid_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Request was unsupported |
| cost_o | output | 16 | Transaction cost in bytes |

## Verification
Every result appears on the clock edge that follows the edge which samples req_i, through one register stage. The bench drives each request on a falling edge and holds it for one cycle. It then reads valid_o, err_o and cost_o at the next falling edge. It checks one falling edge after that to confirm that valid_o has dropped again. Expected costs come from the formulas in the requirements, evaluated in integer arithmetic. The sweep covers every speed, type, direction, phase and multiplier, over packet sizes that straddle the multiples of 6 and the 1024 limit.

// File: rtl/usb_cost_pkg.sv
package usb_cost_pkg;
  typedef enum logic [1:0] {
    SPD_FULL = 2'd0,
    SPD_LOW  = 2'd1,
    SPD_HIGH = 2'd2,
    SPD_RSVD = 2'd3
  } speed_e;

  typedef enum logic [1:0] {
    PH_NONE  = 2'd0,
    PH_START = 2'd1,
    PH_COMPL = 2'd2,
    PH_RSVD  = 2'd3
  } phase_e;

  localparam int HOST_DLY       = 18;
  localparam int FS_OVH_ASYNC   = 14;
  localparam int FS_OVH_ISO_OUT = 10;
  localparam int FS_OVH_ISO_IN  = 11;
  localparam int LS_OVH         = 97;
  localparam int LS_HUB_OVH     = 1;
  localparam int LS_SCALE       = 8;
  localparam int HS_OVH_ASYNC   = 55;
  localparam int HS_OVH_ISO     = 38;
  localparam int SPLIT_OVH      = 4;
  localparam int STUFF_NUM      = 7;
  localparam int STUFF_DEN      = 6;
endpackage

// File: rtl/usb_stuff_payload.sv
module usb_stuff_payload #(
  parameter int MPS_W = 11,
  parameter int PAY_W = MPS_W + 1
) (
  input  logic [MPS_W-1:0] mps_i,
  output logic [PAY_W-1:0] pay_o
);
  import usb_cost_pkg::*;

  localparam int PROD_W = MPS_W + 3;

  logic [PROD_W-1:0] prod;

  always_comb begin
    prod  = PROD_W'(mps_i) * PROD_W'(STUFF_NUM);
    pay_o = PAY_W'(prod / PROD_W'(STUFF_DEN));
  end
endmodule

// File: rtl/usb_ovh_sel.sv
module usb_ovh_sel #(
  parameter int COST_W = 16
) (
  input  logic [1:0]        speed_i,
  input  logic              iso_i,
  input  logic              dir_in_i,
  input  logic [1:0]        split_i,
  output logic [COST_W-1:0] fixed_o,
  output logic              pay_en_o,
  output logic              pay_x8_o,
  output logic              use_mult_o
);
  import usb_cost_pkg::*;

  speed_e spd;
  phase_e ph;
  int     hs_base;

  always_comb begin
    spd        = speed_e'(speed_i);
    ph         = phase_e'(split_i);
    hs_base    = iso_i ? HS_OVH_ISO : HS_OVH_ASYNC;
    fixed_o    = '0;
    pay_en_o   = 1'b1;
    pay_x8_o   = 1'b0;
    use_mult_o = 1'b0;
    unique case (spd)
      SPD_FULL: begin
        if (!iso_i)        fixed_o = COST_W'(FS_OVH_ASYNC + HOST_DLY);
        else if (dir_in_i) fixed_o = COST_W'(FS_OVH_ISO_IN + HOST_DLY);
        else               fixed_o = COST_W'(FS_OVH_ISO_OUT + HOST_DLY);
      end
      SPD_LOW: begin
        fixed_o  = COST_W'(LS_OVH + LS_HUB_OVH + HOST_DLY);
        pay_x8_o = 1'b1;
      end
      SPD_HIGH: begin
        unique case (ph)
          PH_NONE: begin
            fixed_o    = COST_W'(hs_base + HOST_DLY);
            use_mult_o = 1'b1;
          end
          PH_START: begin
            fixed_o  = COST_W'(hs_base + HOST_DLY + SPLIT_OVH);
            pay_en_o = !dir_in_i;  // OUT payload rides the start phase
          end
          PH_COMPL: begin
            fixed_o  = COST_W'(hs_base + HOST_DLY + SPLIT_OVH);
            pay_en_o = dir_in_i;   // IN payload returns in the complete phase
          end
          default: begin
            fixed_o  = '0;
            pay_en_o = 1'b0;
          end
        endcase
      end
      default: begin
        fixed_o  = '0;
        pay_en_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/usb_req_check.sv
module usb_req_check #(
  parameter int MPS_W    = 11,
  parameter int MPS_MAX  = 1024,
  parameter int MULT_W   = 2,
  parameter int MULT_MAX = 3
) (
  input  logic [1:0]        speed_i,
  input  logic [1:0]        split_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic [MPS_W-1:0]  mps_i,
  output logic              err_o
);
  import usb_cost_pkg::*;

  logic hs, bad_mps, bad_spd, bad_ph, bad_mult;

  always_comb begin
    hs       = speed_e'(speed_i) == SPD_HIGH;
    bad_mps  = 32'(mps_i) > MPS_MAX;
    bad_spd  = speed_e'(speed_i) == SPD_RSVD;
    bad_ph   = hs && phase_e'(split_i) == PH_RSVD;
    bad_mult = hs && phase_e'(split_i) == PH_NONE &&
               (mult_i == '0 || 32'(mult_i) > MULT_MAX);
    err_o    = bad_mps | bad_spd | bad_ph | bad_mult;
  end
endmodule

// File: rtl/usb_xact_cost.sv
module usb_xact_cost #(
  parameter int MPS_W    = 11,
  parameter int MPS_MAX  = 1024,
  parameter int MULT_W   = 2,
  parameter int MULT_MAX = 3,
  parameter int COST_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        speed_i,
  input  logic              iso_i,
  input  logic              dir_in_i,
  input  logic [1:0]        split_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic [MPS_W-1:0]  mps_i,
  output logic              valid_o,
  output logic              err_o,
  output logic [COST_W-1:0] cost_o
);
  import usb_cost_pkg::*;

  localparam int PAY_W = MPS_W + 1;

  logic [PAY_W-1:0]  pay;
  logic [COST_W-1:0] fixed, pay_term, base, cost_d;
  logic              pay_en, pay_x8, use_mult, err_d;

  usb_stuff_payload #(.MPS_W(MPS_W), .PAY_W(PAY_W)) u_pay (
    .mps_i (mps_i),
    .pay_o (pay)
  );

  usb_ovh_sel #(.COST_W(COST_W)) u_ovh (
    .speed_i    (speed_i),
    .iso_i      (iso_i),
    .dir_in_i   (dir_in_i),
    .split_i    (split_i),
    .fixed_o    (fixed),
    .pay_en_o   (pay_en),
    .pay_x8_o   (pay_x8),
    .use_mult_o (use_mult)
  );

  usb_req_check #(
    .MPS_W(MPS_W), .MPS_MAX(MPS_MAX), .MULT_W(MULT_W), .MULT_MAX(MULT_MAX)
  ) u_chk (
    .speed_i (speed_i),
    .split_i (split_i),
    .mult_i  (mult_i),
    .mps_i   (mps_i),
    .err_o   (err_d)
  );

  always_comb begin
    if (!pay_en)     pay_term = '0;
    else if (pay_x8) pay_term = COST_W'(pay) * COST_W'(LS_SCALE);
    else             pay_term = COST_W'(pay);
    base = fixed + pay_term;
    if (err_d)         cost_d = '0;
    else if (use_mult) cost_d = base * COST_W'(mult_i);
    else               cost_d = base;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      cost_o  <= '0;
    end else begin
      valid_o <= req_i;
      if (req_i) begin
        err_o  <= err_d;
        cost_o <= cost_d;
      end
    end
  end

  p_valid_after_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  p_no_stray_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o);
  p_err_zero_cost_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && err_o |-> cost_o == '0);
  p_oversize_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && (32'(mps_i) > MPS_MAX) |=> valid_o && err_o);
  p_host_delay_floor_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !err_o && cost_o != '0 |-> 32'(cost_o) >= HOST_DLY);
endmodule

// File: tb/usb_xact_cost_tb.sv
`timescale 1ns/1ps
module usb_xact_cost_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  speed = '0;
  logic        iso = 1'b0;
  logic        dir_in = 1'b0;
  logic [1:0]  split = '0;
  logic [1:0]  mult = '0;
  logic [10:0] mps = '0;
  logic        valid, err;
  logic [15:0] cost;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usb_xact_cost u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .speed_i(speed), .iso_i(iso),
    .dir_in_i(dir_in), .split_i(split), .mult_i(mult), .mps_i(mps),
    .valid_o(valid), .err_o(err), .cost_o(cost)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d (spd=%0d iso=%0d in=%0d ph=%0d mult=%0d mps=%0d)",
               tag, act, exp, speed, iso, dir_in, split, mult, mps);
    end
  endtask

  task automatic model(input int s, input int i, input int d, input int ph,
                       input int m, input int p, output int c, output int e,
                       output string tag);
    int pay, h;
    pay = (p * 7) / 6;
    e = 0; c = 0;
    h = i ? 38 : 55;
    if (p > 1024) begin e = 1; tag = "R8"; end
    else if (s == 3) begin e = 1; tag = "R8"; end
    else if (s == 0) begin
      c = (i ? (d ? 11 : 10) : 14) + pay + 18;
      tag = (ph != 0 || m != 1) ? "R10" : ((p % 6 != 0) ? "R1" : "R2");
    end else if (s == 1) begin
      c = 97 + 1 + 8 * pay + 18;
      tag = (ph != 0 || m != 1) ? "R10" : "R3";
    end else if (ph == 3) begin e = 1; tag = "R8"; end
    else if (ph == 0) begin
      if (m == 0) begin e = 1; tag = "R8"; end
      else begin c = (h + pay + 18) * m; tag = "R4"; end
    end else if (ph == 1) begin
      c = h + 22 + (d ? 0 : pay); tag = "R5";
    end else begin
      c = h + 22 + (d ? pay : 0); tag = "R6";
    end
  endtask

  task automatic run_one(input int s, input int i, input int d, input int ph,
                         input int m, input int p);
    int ec, ee;
    string tag;
    model(s, i, d, ph, m, p, ec, ee, tag);
    @(negedge clk);
    speed = 2'(s); iso = 1'(i); dir_in = 1'(d); split = 2'(ph);
    mult = 2'(m); mps = 11'(p); req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check("R7", int'(valid), 1);
    check(tag, int'(err), ee);
    check(tag, int'(cost), ec);
    @(negedge clk);
    check("R7", int'(valid), 0);
  endtask

  initial begin
    int sizes[13] = '{0, 1, 5, 6, 7, 8, 64, 511, 512, 1023, 1024, 1025, 2047};
    #1;
    // R9: reset values
    check("R9", int'(valid), 0);
    check("R9", int'(err), 0);
    check("R9", int'(cost), 0);
    repeat (3) @(negedge clk);
    check("R9", int'(valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R7", int'(valid), 0);
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 2; i++)
        for (int d = 0; d < 2; d++)
          for (int ph = 0; ph < 4; ph++)
            for (int m = 0; m < 4; m++)
              for (int k = 0; k < 13; k++)
                run_one(s, i, d, ph, m, sizes[k]);
    // back-to-back strobes, R7
    @(negedge clk);
    speed = 2'd2; iso = 1'b0; split = 2'd0; mult = 2'd3; mps = 11'd1024; req = 1'b1;
    @(negedge clk);
    check("R7", int'(valid), 1);
    check("R4", int'(cost), (55 + 1194 + 18) * 3);
    speed = 2'd1;
    @(negedge clk);
    req = 1'b0;
    check("R7", int'(valid), 1);
    check("R3", int'(cost), 116 + 8 * 1194);
    @(negedge clk);
    check("R7", int'(valid), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R7 act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule